// File: doc/BRIEF.md
# Prescaled Reloading Down-Counter Timer

This block is an 8-bit down-counter driven by a prescaler that divides the timer clock enable. A 4-bit mode code picks one of four modes. The timer can be stopped. In delay mode it runs with one of seven prescale divisors. In event-count mode the counter steps once for each qualified active transition of an auxiliary input. In pulse-width mode the prescaler and counter run only while the auxiliary input is at its active level.

When the counter passes through one, it does not fall to zero. It reloads from a data register and emits a one-cycle time-out pulse, and that pulse also toggles an output pin. The block also produces a conditioned copy of the auxiliary input for a neighbouring interrupt channel. In pulse-width mode that copy is inverted, so the neighbour's edge detector fires when the measured pulse ends.

Software reaches the block through a small register port. Selector 0 is the control byte: bits [3:0] hold the mode code, and bit 4 is a write-only output clear. Selector 1 is the data register. A read port returns either the mode code or the live counter.

Top module: `ptmr_timer`

## Requirements
- R1: The mode code decodes as follows. 0000 stops the timer. 0001 to 0111 select delay mode with divisors 4, 10, 16, 50, 64, 100 and 200, in that order. 1000 selects event count. 1001 to 1111 select pulse-width mode with the same divisor sequence. In delay mode, with a tick on every cycle, the time-out period is divisor × reload value clock cycles.
- R2: On a count pulse with the counter at 1, the counter reloads from the data register instead of reaching 0. `timeout` is high for exactly one cycle, in the cycle after that reload edge.
- R3: A reload value of 0 gives one time-out per 256 count pulses. A reload value of 1 gives one time-out per count pulse.
- R4: In stop mode the counter holds its value, and any partial prescaler count is discarded. After a restart, the first decrement comes a full divisor of ticks later.
- R5: A data write (selector 1) while stopped loads both the data register and the counter. While running, it loads only the data register, and the new value first appears in the counter at the next reload.
- R6: `tout_pin` toggles at each time-out. A control write with bit 4 set drives `tout_pin` low and leaves the mode code unchanged.
- R7: In event-count mode the prescaler is bypassed. Each active transition of the qualified auxiliary input decrements the counter. The transition is rising when `aux_level`=1 and falling when `aux_level`=0.
- R8: In pulse-width mode the timer runs only while the qualified auxiliary input equals `aux_level`; otherwise the counter is frozen. `irq_src` equals the qualified auxiliary level in other modes and its inverse in pulse-width mode.
- R9: Reset sets the mode code to stop, drives `tout_pin` and `timeout` low, and leaves the data register and the counter untouched.
- R10: A new auxiliary level is accepted only after the synchronised input has differed from the accepted level on 4 consecutive tick cycles. Shorter glitches produce no count.
- R11: With `rd_sel`=0, `rd_data` returns {4'b0, mode code}. With `rd_sel`=1, it returns the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| aux_in | input | 1 | Asynchronous auxiliary input |
| aux_level | input | 1 | Active level / active edge select (1 = high / rising) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 mode code, 1 counter |
| rd_data | output | 8 | Read data |
| timeout | output | 1 | One-cycle time-out pulse |
| tout_pin | output | 1 | Output toggled at each time-out |
| irq_src | output | 1 | Conditioned auxiliary level for an interrupt channel |

## Verification
The assertions assume that reset is held for at least one clock edge before any checked cycle. They also assume that a data write never lands in the same cycle as a reload, because that case has no defined result. The stimulus meets both conditions. It holds reset for several cycles. It performs every running-mode data write with `tick` held low, so no count pulse can coincide with the write. It changes the auxiliary input only in steps much longer than the four-tick qualification window, except in the one glitch test that checks rejection.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CNT_W = 8;
    localparam int PRE_W = 8;

    typedef enum logic [1:0] {
        K_STOP  = 2'd0,
        K_DELAY = 2'd1,
        K_EVENT = 2'd2,
        K_PULSE = 2'd3
    } tkind_e;

    typedef struct packed {
        tkind_e     kind;
        logic [2:0] psel;
    } tcfg_t;

    function automatic tcfg_t decode_mode(input logic [3:0] code);
        tcfg_t c;
        c.psel = code[2:0];
        if (code == 4'h0)      c.kind = K_STOP;
        else if (code == 4'h8) c.kind = K_EVENT;
        else if (code[3])      c.kind = K_PULSE;
        else                   c.kind = K_DELAY;
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] prescale_div(input logic [2:0] psel);
        case (psel)
            3'd1:    return PRE_W'(4);
            3'd2:    return PRE_W'(10);
            3'd3:    return PRE_W'(16);
            3'd4:    return PRE_W'(50);
            3'd5:    return PRE_W'(64);
            3'd6:    return PRE_W'(100);
            3'd7:    return PRE_W'(200);
            default: return PRE_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/ptmr_aux_cond.sv
module ptmr_aux_cond #(
    parameter int STABLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic aux_in,
    input  logic aux_level,
    input  logic pw_mode,
    output logic act,
    output logic event_p,
    output logic irq_src
);
    localparam int SW = $clog2(STABLE_TICKS + 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [SW-1:0] scnt_q;
    logic          act_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b00;
            filt_q  <= 1'b0;
            scnt_q  <= '0;
            act_d_q <= 1'b1;
        end else begin
            sync_q  <= {sync_q[0], aux_in};
            act_d_q <= act;
            if (tick) begin
                if (sync_q[1] == filt_q) begin
                    scnt_q <= '0;
                end else if (scnt_q == SW'(STABLE_TICKS - 1)) begin
                    filt_q <= sync_q[1];
                    scnt_q <= '0;
                end else begin
                    scnt_q <= scnt_q + SW'(1);
                end
            end
        end
    end

    assign act     = (filt_q == aux_level);
    assign event_p = act & ~act_d_q;
    assign irq_src = pw_mode ? ~filt_q : filt_q;

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic       clear,
    input  logic [2:0] psel,
    output logic       cpulse
);
    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] last;

    assign last   = prescale_div(psel) - PRE_W'(1);
    assign cpulse = run & tick & (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt_q <= '0;
        end else if (run && tick) begin
            pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpulse,
    input  logic         data_we,
    input  logic         load_cnt,
    input  logic [W-1:0] wr_data,
    input  logic         force_low,
    output logic [W-1:0] count,
    output logic [W-1:0] dreg,
    output logic         timeout,
    output logic         pin
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] dreg_q;
    logic         wrap;

    assign wrap = cpulse && (cnt_q == W'(1));

    // Counter and data register survive reset by design.
    always_ff @(posedge clk) begin
        if (cpulse) begin
            cnt_q <= wrap ? dreg_q : cnt_q - W'(1);
        end
        if (data_we && load_cnt) begin
            cnt_q <= wr_data;
        end
        if (data_we) begin
            dreg_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timeout <= 1'b0;
            pin     <= 1'b0;
        end else begin
            timeout <= wrap;
            if (force_low)  pin <= 1'b0;
            else if (wrap)  pin <= ~pin;
        end
    end

    assign count = cnt_q;
    assign dreg  = dreg_q;

endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
    import ptmr_pkg::*;
#(
    parameter int W            = CNT_W,
    parameter int STABLE_TICKS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         aux_in,
    input  logic         aux_level,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    output logic         timeout,
    output logic         tout_pin,
    output logic         irq_src
);
    logic [3:0]   ctrl_mode;
    tcfg_t        cfg;
    logic         ctrl_we, data_we, force_low;
    logic         act, event_p, presc_pulse, cpulse, run;
    logic [W-1:0] cnt_q, dreg_q;

    assign ctrl_we   = wr_en && !wr_sel;
    assign data_we   = wr_en &&  wr_sel;
    assign force_low = ctrl_we && wr_data[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_mode <= 4'h0;
        end else if (ctrl_we && !wr_data[4]) begin
            ctrl_mode <= wr_data[3:0];
        end
    end

    assign cfg = decode_mode(ctrl_mode);
    assign run = (cfg.kind == K_DELAY) || ((cfg.kind == K_PULSE) && act);

    ptmr_aux_cond #(.STABLE_TICKS(STABLE_TICKS)) u_aux (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .aux_in   (aux_in),
        .aux_level(aux_level),
        .pw_mode  (cfg.kind == K_PULSE),
        .act      (act),
        .event_p  (event_p),
        .irq_src  (irq_src)
    );

    ptmr_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .run   (run),
        .clear (cfg.kind == K_STOP || cfg.kind == K_EVENT),
        .psel  (cfg.psel),
        .cpulse(presc_pulse)
    );

    assign cpulse = (cfg.kind == K_EVENT) ? event_p : presc_pulse;

    ptmr_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cpulse   (cpulse),
        .data_we  (data_we),
        .load_cnt (cfg.kind == K_STOP),
        .wr_data  (wr_data),
        .force_low(force_low),
        .count    (cnt_q),
        .dreg     (dreg_q),
        .timeout  (timeout),
        .pin      (tout_pin)
    );

    assign rd_data = rd_sel ? cnt_q : {{(W-4){1'b0}}, ctrl_mode};

endmodule

// File: rtl/ptmr_timer_chk.sv
module ptmr_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         wr_sel,
    input logic [W-1:0] wr_data,
    input logic [3:0]   mode,
    input logic [W-1:0] count,
    input logic [W-1:0] dreg,
    input logic         timeout,
    input logic         tout_pin
);
    AST_STOP_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'h0) |=> !timeout);                                        // R1

    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);                                               // R2

    AST_TIMEOUT_RELOADS: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (count == $past(dreg)));                                 // R2

    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($past(mode == 4'h0) && !$past(wr_en && wr_sel)) |-> $stable(count)); // R4

    AST_PIN_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (timeout && !$past(wr_en && !wr_sel && wr_data[4]))
            |-> (tout_pin != $past(tout_pin)));                              // R6

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!timeout && !$past(wr_en && !wr_sel && wr_data[4]))
            |-> $stable(tout_pin));                                          // R6

    AST_CLEAR_BIT_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_data[4]) |=> (!tout_pin && $stable(mode)));  // R6

endmodule

bind ptmr_timer ptmr_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mode    (ctrl_mode),
    .count   (cnt_q),
    .dreg    (dreg_q),
    .timeout (timeout),
    .tout_pin(tout_pin)
);

// File: tb/sim_ptmr_timer.sv
`timescale 1ns/1ps
module sim_ptmr_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       aux_in = 1'b0;
    logic       aux_level = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b1;
    logic [7:0] rd_data;
    logic       timeout, tout_pin, irq_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ptmr_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .aux_in(aux_in), .aux_level(aux_level),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .timeout(timeout), .tout_pin(tout_pin), .irq_src(irq_src)
    );

    // {mode code, reload value, expected period in cycles}
    localparam logic [23:0] VEC [8] = '{
        {4'h1, 8'd3, 12'd12},
        {4'h2, 8'd2, 12'd20},
        {4'h3, 8'd1, 12'd16},
        {4'h4, 8'd2, 12'd100},
        {4'h5, 8'd1, 12'd64},
        {4'h6, 8'd1, 12'd100},
        {4'h7, 8'd1, 12'd200},
        {4'h1, 8'd0, 12'd1024}
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_cnt(output int v);
        rd_sel = 1'b1; #1; v = rd_data;
    endtask

    task automatic read_mode(output int v);
        rd_sel = 1'b0; #1; v = rd_data; rd_sel = 1'b1;
    endtask

    task automatic wait_to(input string req);
        int n = 0;
        do begin
            @(negedge clk); n++;
        end while (!timeout && n < 5000);
        if (!timeout) check(req, 0, 1);
    endtask

    task automatic measure(input logic [3:0] code, input logic [7:0] n, input int per);
        int  cyc = 0;
        logic p0;
        wr(1'b0, 8'h00);
        wr(1'b1, n);
        wr(1'b0, {4'h0, code});
        wait_to("R1");
        p0 = tout_pin;
        do begin
            @(negedge clk); cyc++;
        end while (!timeout && cyc < 5000);
        check((n <= 1) ? "R3 period" : "R1 period", cyc, per);
        check("R6 toggle", int'(tout_pin), int'(!p0));
    endtask

    task automatic aux_hold(input logic v, input int n);
        @(negedge clk); aux_in = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int v, v2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 / R11 reset state
        read_mode(v); check("R9 mode after reset", v, 0);
        check("R9 pin after reset", int'(tout_pin), 0);
        check("R9 timeout after reset", int'(timeout), 0);

        // R1 / R3 / R6 table
        foreach (VEC[i]) measure(VEC[i][23:20], VEC[i][19:12], int'(VEC[i][11:0]));

        // R11 read mode code
        wr(1'b0, 8'h05); read_mode(v); check("R11 mode readback", v, 5);

        // R5 stopped data write loads counter; R4 residual discard
        wr(1'b0, 8'h00); wr(1'b1, 8'd5);
        read_cnt(v); check("R5 stopped load", v, 5);
        wr(1'b0, 8'h01);
        @(negedge clk);
        wr(1'b0, 8'h00);
        repeat (3) @(negedge clk);
        read_cnt(v); check("R4 stop holds", v, 5);
        wr(1'b0, 8'h01);
        repeat (3) @(negedge clk);
        read_cnt(v); check("R4 residual discarded", v, 5);
        @(negedge clk);
        read_cnt(v); check("R4 first decrement", v, 4);

        // R5 running write defers to reload
        tick = 1'b0;
        wr(1'b1, 8'd9);
        read_cnt(v); check("R5 running write no load", v, 4);
        tick = 1'b1;
        wait_to("R5");
        read_cnt(v); check("R5 reload uses new data", v, 9);

        // R6 forced low, mode unchanged
        wr(1'b0, 8'h00); wr(1'b1, 8'd1); wr(1'b0, 8'h10);
        wr(1'b0, 8'h01);
        wait_to("R6");
        tick = 1'b0;
        check("R6 pin high after one timeout", int'(tout_pin), 1);
        wr(1'b0, 8'h10);
        check("R6 pin forced low", int'(tout_pin), 0);
        read_mode(v); check("R6 mode kept", v, 1);
        tick = 1'b1;

        // R9 reset keeps counter
        wr(1'b0, 8'h00); wr(1'b1, 8'h5A);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        read_cnt(v); check("R9 counter survives reset", v, 'h5A);

        // R7 event count, rising edges; R10 glitch
        aux_level = 1'b1; aux_in = 1'b0;
        wr(1'b1, 8'd3); wr(1'b0, 8'h08);
        aux_hold(1'b1, 12); aux_hold(1'b0, 12);
        read_cnt(v); check("R7 one event", v, 2);
        aux_hold(1'b1, 2); aux_hold(1'b0, 12);
        read_cnt(v); check("R10 glitch ignored", v, 2);
        aux_hold(1'b1, 12); aux_hold(1'b0, 12);
        read_cnt(v); check("R7 second event", v, 1);
        aux_hold(1'b1, 12); aux_hold(1'b0, 12);
        read_cnt(v); check("R7 reload after third event", v, 3);

        // R7 falling edges with aux_level 0
        wr(1'b0, 8'h00);
        aux_level = 1'b0; aux_hold(1'b1, 12);
        wr(1'b1, 8'd5); wr(1'b0, 8'h08);
        aux_hold(1'b0, 12); aux_hold(1'b1, 12);
        read_cnt(v); check("R7 falling event", v, 4);

        // R8 pulse-width gating and inverted interrupt source
        wr(1'b0, 8'h00);
        aux_level = 1'b1; aux_hold(1'b0, 12);
        wr(1'b1, 8'd100); wr(1'b0, 8'h09);
        repeat (40) @(negedge clk);
        read_cnt(v); check("R8 frozen while inactive", v, 100);
        check("R8 irq_src inverted low level", int'(irq_src), 1);
        aux_hold(1'b1, 60);
        check("R8 irq_src inverted high level", int'(irq_src), 0);
        aux_hold(1'b0, 20);
        read_cnt(v);
        check("R8 counted during pulse", int'(v < 100 && v > 80), 1);
        repeat (40) @(negedge clk);
        read_cnt(v2); check("R8 frozen after pulse", v2, v);
        wr(1'b0, 8'h01); aux_hold(1'b1, 12);
        check("R8 irq_src plain in delay mode", int'(irq_src), 1);

        finish_run();
    end

endmodule